// File: doc/BRIEF.md
# Floating-Point Status Register

This block holds the 32-bit status word of a floating-point unit. Each time the unit finishes an operation it presents four condition flags and an 8-bit set of exception flags, with a one-cycle valid strobe. The register stores the condition flags and the exception byte as the state of the latest operation. It also merges the exception byte into a five-bit accrued field. Bits in the accrued field stay set across later operations.

Software can write the whole word directly. A write loads every live field from the data input and overrides any operation update in the same cycle. The reserved positions always read zero. The full word is visible on the read output one cycle after any change.

Top module: `fpu_status_unit`

## Requirements
- R1: A synchronous active-high `rst` clears all 32 bits of `status` to zero on the next clock edge.
- R2: When `op_valid` is high and `sw_we` is low, the next `status[27:24]` equals `op_cc` (bit 27 negative, 26 zero, 25 infinity, 24 not-a-number) and the next `status[15:8]` equals `op_exc`. The `op_exc` bit order is 7 unordered compare, 6 NaN operand, 5 operand error, 4 overflow, 3 underflow, 2 divide by zero, 1 inexact, 0 denormal input. Both fields are fully replaced.
- R3: On an operation update, accrued overflow (`status[6]`), divide by zero (`status[4]`) and inexact (`status[3]`) are each ORed with `op_exc[4]`, `op_exc[2]` and `op_exc[1]` respectively.
- R4: On an operation update, accrued invalid (`status[7]`) is ORed with the OR of `op_exc[7]`, `op_exc[6]` and `op_exc[5]`.
- R5: On an operation update, accrued underflow (`status[5]`) is ORed with `op_exc[3] & op_exc[1]`. An underflow that is not inexact leaves it unchanged.
- R6: An operation update never clears an accrued bit. Only a software write or reset does.
- R7: When `sw_we` is high, the next `status` equals `sw_wdata & 32'h0F00_FFF8`. Bits 31:28, 23:16 and 2:0 always read zero.
- R8: When `sw_we` and `op_valid` are both high in one cycle, the write alone decides the next value.
- R9: With `sw_we` and `op_valid` both low, `status` holds its value, whatever the flag inputs carry.
- R10: The denormal-input bit (`op_exc[0]`) appears at `status[8]` and has no effect on any accrued bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_we | input | 1 | Software write enable |
| sw_wdata | input | 32 | Software write data |
| op_valid | input | 1 | Operation-complete strobe |
| op_cc | input | 4 | Condition flags of the operation |
| op_exc | input | 8 | Exception flags of the operation |
| status | output | 32 | Register read value |

## Verification
The software write and the operation update can arrive in the same cycle. The bench provokes this in two ways. It pairs a write with an operation whose flags would set every accrued bit, and it pairs a zero write with accrued bits already set. In both cases the read value on the following cycle must equal the masked write data exactly, with no trace of the operation's flags. The bench also covers write-only and operation-only cycles, the underflow-without-inexact case and the denormal-only case, and compares each result against an independent model.

// File: rtl/fsr_pkg.sv
`timescale 1ns/1ps
package fsr_pkg;

    localparam int STATUS_W = 32;
    localparam int CC_W     = 4;
    localparam int EXC_W    = 8;
    localparam int ACC_W    = 5;

    // Least significant bit of each live field inside the status word
    localparam int CC_LSB   = 24;
    localparam int EXC_LSB  = 8;
    localparam int ACC_LSB  = 3;

    localparam logic [STATUS_W-1:0] LIVE_MASK =
        (((STATUS_W)'(1) << CC_W)  - 1) << CC_LSB  |
        (((STATUS_W)'(1) << EXC_W) - 1) << EXC_LSB |
        (((STATUS_W)'(1) << ACC_W) - 1) << ACC_LSB;

    typedef struct packed {
        logic neg;
        logic zero;
        logic inf;
        logic nan;
    } cc_t;

    typedef struct packed {
        logic unord;
        logic in_nan;
        logic op_err;
        logic ovf;
        logic unf;
        logic div0;
        logic inexact;
        logic denorm;
    } exc_t;

    typedef struct packed {
        logic invalid;
        logic ovf;
        logic unf;
        logic div0;
        logic inexact;
    } acc_t;

    typedef struct packed {
        cc_t  cc;
        exc_t exc;
        acc_t acc;
    } fields_t;

    // Merge one operation's exceptions into the sticky field
    function automatic acc_t fold(input acc_t prev, input exc_t e);
        acc_t n;
        n.invalid = prev.invalid | e.unord | e.in_nan | e.op_err;
        n.ovf     = prev.ovf     | e.ovf;
        n.unf     = prev.unf     | (e.unf & e.inexact);
        n.div0    = prev.div0    | e.div0;
        n.inexact = prev.inexact | e.inexact;
        return n;
    endfunction

    function automatic logic [STATUS_W-1:0] pack(input fields_t f);
        logic [STATUS_W-1:0] w;
        w = '0;
        w[CC_LSB  +: CC_W]  = f.cc;
        w[EXC_LSB +: EXC_W] = f.exc;
        w[ACC_LSB +: ACC_W] = f.acc;
        return w;
    endfunction

endpackage

// File: rtl/fsr_field_reg.sv
`timescale 1ns/1ps
module fsr_field_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end

endmodule

// File: rtl/fsr_accrue.sv
`timescale 1ns/1ps
module fsr_accrue
    import fsr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sw_load,
    input  acc_t sw_val,
    input  logic op_load,
    input  exc_t op_exc,
    output acc_t q
);

    acc_t nxt;

    always_comb begin
        nxt = q;
        if (sw_load)      nxt = sw_val;
        else if (op_load) nxt = fold(q, op_exc);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

endmodule

// File: rtl/fpu_status_unit.sv
`timescale 1ns/1ps
module fpu_status_unit
    import fsr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sw_we,
    input  logic [STATUS_W-1:0] sw_wdata,
    input  logic                op_valid,
    input  logic [CC_W-1:0]     op_cc,
    input  logic [EXC_W-1:0]    op_exc,
    output logic [STATUS_W-1:0] status
);

    fields_t wr_f;
    fields_t cur;
    logic    live_load;
    cc_t     cc_d;
    exc_t    exc_d;
    logic    unused_rsvd;

    always_comb begin
        wr_f.cc  = cc_t'(sw_wdata[CC_LSB  +: CC_W]);
        wr_f.exc = exc_t'(sw_wdata[EXC_LSB +: EXC_W]);
        wr_f.acc = acc_t'(sw_wdata[ACC_LSB +: ACC_W]);
    end

    assign unused_rsvd = ^(sw_wdata & ~LIVE_MASK);

    // Software write has priority over an operation in the same cycle
    assign live_load = sw_we | op_valid;
    assign cc_d      = sw_we ? wr_f.cc  : cc_t'(op_cc);
    assign exc_d     = sw_we ? wr_f.exc : exc_t'(op_exc);

    fsr_field_reg #(.W(CC_W)) u_cc (
        .clk  (clk),
        .rst  (rst),
        .load (live_load),
        .d    (cc_d),
        .q    (cur.cc)
    );

    fsr_field_reg #(.W(EXC_W)) u_exc (
        .clk  (clk),
        .rst  (rst),
        .load (live_load),
        .d    (exc_d),
        .q    (cur.exc)
    );

    fsr_accrue u_acc (
        .clk     (clk),
        .rst     (rst),
        .sw_load (sw_we),
        .sw_val  (wr_f.acc),
        .op_load (op_valid),
        .op_exc  (exc_t'(op_exc)),
        .q       (cur.acc)
    );

    assign status = pack(cur);

endmodule

// File: rtl/fsr_checker.sv
`timescale 1ns/1ps
module fsr_checker
    import fsr_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                sw_we,
    input logic [STATUS_W-1:0] sw_wdata,
    input logic                op_valid,
    input logic [CC_W-1:0]     op_cc,
    input logic [EXC_W-1:0]    op_exc,
    input logic [STATUS_W-1:0] status
);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> status == '0);

    a_r2_fields_replaced: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !sw_we) |=>
            (status[27:24] == $past(op_cc) && status[15:8] == $past(op_exc)));

    a_r4_invalid_merge: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !sw_we && (op_exc[7] || op_exc[6] || op_exc[5])) |=> status[7]);

    a_r5_underflow_gate: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !sw_we && !status[5] && !(op_exc[3] && op_exc[1])) |=> !status[5]);

    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        !sw_we |=> ((status[7:3] & $past(status[7:3])) == $past(status[7:3])));

    a_r7_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (status & ~LIVE_MASK) == '0);

    a_r8_write_wins: assert property (@(posedge clk) disable iff (rst)
        sw_we |=> status == ($past(sw_wdata) & LIVE_MASK));

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (!sw_we && !op_valid) |=> $stable(status));

endmodule

bind fpu_status_unit fsr_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .sw_we    (sw_we),
    .sw_wdata (sw_wdata),
    .op_valid (op_valid),
    .op_cc    (op_cc),
    .op_exc   (op_exc),
    .status   (status)
);

// File: tb/fpu_status_unit_tb.sv
`timescale 1ns/1ps
module fpu_status_unit_tb;

    localparam int N_VEC = 11;
    localparam int VEC_W = 46;
    localparam logic [31:0] MASK = 32'h0F00_FFF8;

    // {we, wdata[31:0], opv, cc[3:0], exc[7:0]}
    localparam logic [VEC_W-1:0] VEC [N_VEC] = '{
        {1'b0, 32'h0,         1'b1, 4'b1000, 8'h10},  // overflow
        {1'b0, 32'h0,         1'b1, 4'b0100, 8'h08},  // underflow alone (R5)
        {1'b0, 32'h0,         1'b1, 4'b0010, 8'h0A},  // underflow + inexact
        {1'b0, 32'h0,         1'b1, 4'b0001, 8'h80},  // unordered (R4)
        {1'b0, 32'h0,         1'b1, 4'b0000, 8'h04},  // divide by zero
        {1'b0, 32'h0,         1'b1, 4'b0000, 8'h00},  // clean op: sticky (R6)
        {1'b0, 32'h0,         1'b0, 4'b1111, 8'hFF},  // idle: hold (R9)
        {1'b1, 32'h0,         1'b0, 4'b0000, 8'h00},  // clear by write
        {1'b0, 32'h0,         1'b1, 4'b1100, 8'h40},  // NaN operand (R4)
        {1'b0, 32'h0,         1'b1, 4'b0011, 8'h20},  // operand error (R4)
        {1'b0, 32'h0,         1'b1, 4'b0101, 8'h01}   // denormal only (R10)
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sw_we = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_cc = '0;
    logic [7:0]  op_exc = '0;
    logic [31:0] status;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] model = '0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    fpu_status_unit u_dut (
        .clk      (clk),
        .rst      (rst),
        .sw_we    (sw_we),
        .sw_wdata (sw_wdata),
        .op_valid (op_valid),
        .op_cc    (op_cc),
        .op_exc   (op_exc),
        .status   (status)
    );

    function automatic logic [31:0] next_model(input logic [31:0] cur, input logic we,
            input logic [31:0] wd, input logic ov, input logic [3:0] cc, input logic [7:0] ex);
        logic [31:0] n;
        if (we) return wd & MASK;
        if (!ov) return cur;
        n = '0;
        n[27:24] = cc;
        n[15:8]  = ex;
        n[7] = cur[7] | ex[7] | ex[6] | ex[5];
        n[6] = cur[6] | ex[4];
        n[5] = cur[5] | (ex[3] & ex[1]);
        n[4] = cur[4] | ex[2];
        n[3] = cur[3] | ex[1];
        return n;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Drive one cycle after a falling edge, sample at the next falling edge
    task automatic step(input logic we, input logic [31:0] wd, input logic ov,
                        input logic [3:0] cc, input logic [7:0] ex);
        sw_we = we; sw_wdata = wd; op_valid = ov; op_cc = cc; op_exc = ex;
        model = next_model(model, we, wd, ov, cc, ex);
        @(negedge clk);
        sw_we = 1'b0; op_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model = '0;
    endtask

    initial begin
        #(20ns * 5000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        check("R1 reset value", status, 32'h0);

        for (int i = 0; i < N_VEC; i++) begin
            logic [VEC_W-1:0] v;
            v = VEC[i];
            step(v[45], v[44:13], v[12], v[11:8], v[7:0]);
            check("R2 cc/exc fields", status & 32'hFFFF_FF00, model & 32'hFFFF_FF00);
            check("R3 R4 R5 R6 accrued", status & 32'h0000_00FF, model & 32'h0000_00FF);
        end

        // R10: denormal only from a clean accrued field
        step(1'b1, 32'h0, 1'b0, 4'h0, 8'h00);
        step(1'b0, 32'h0, 1'b1, 4'h0, 8'h01);
        check("R10 denormal no accrual", status, 32'h0000_0100);

        // R5: underflow without inexact, then with
        step(1'b0, 32'h0, 1'b1, 4'h0, 8'h08);
        check("R5 underflow alone", status, 32'h0000_0800);
        step(1'b0, 32'h0, 1'b1, 4'h0, 8'h0A);
        check("R5 underflow+inexact", status, 32'h0000_0A28);

        // R3: each direct merge
        step(1'b0, 32'h0, 1'b1, 4'h0, 8'h14);
        check("R3 ovf+div0", status, 32'h0000_1478);

        // R7: write all ones, reserved bits read zero
        step(1'b1, 32'hFFFF_FFFF, 1'b0, 4'h0, 8'h00);
        check("R7 reserved masked", status, 32'h0F00_FFF8);

        // R8: write of zero collides with an operation that would set everything
        step(1'b1, 32'h0, 1'b1, 4'hF, 8'hFF);
        check("R8 write wins zero", status, 32'h0);
        step(1'b1, 32'h0300_A5A8, 1'b1, 4'hC, 8'h7E);
        check("R8 write wins pattern", status, 32'h0300_A5A8);

        // R6: clean op keeps accrued bits, replaces current fields
        step(1'b0, 32'h0, 1'b1, 4'h2, 8'h00);
        check("R6 sticky after clean op", status, 32'h0200_00A8);

        // R9: idle cycle with noisy flag inputs
        step(1'b0, 32'hFFFF_FFFF, 1'b0, 4'hF, 8'hFF);
        check("R9 hold idle", status, 32'h0200_00A8);

        // R1: reset after state is set
        do_reset();
        check("R1 reset clears", status, 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule